// File: doc/BRIEF.md
# Paged Data-EEPROM Write Controller

This block fronts a small data EEPROM, held as an internal byte array, on a CPU-side bus. Ordinary byte stores into the mapped EEPROM window do not reach the array. Each store lands in a one-page staging buffer, which marks the byte as written and records the store address in an address register. Reads of the window always return the array contents.

Software makes the buffered bytes permanent with a command. An erase/write command fills the page that holds the most recently stored address: every byte that was staged takes the buffered value, and every other byte of that page becomes 0xFF. A buffer-clear command discards all staged bytes. A command write counts only while a separate protection block holds the `unlock` input high.

An erase/write keeps the controller busy for a fixed number of cycles, set by a parameter. While it is busy, further stores and commands are dropped. When the write finishes, a completion flag sets. Software clears that flag by writing 1 to it.

Top module: `nvm_page_ctrl`

## Requirements
- R1: After reset the command, status, flag and both address registers read 0, and every byte of the window reads 0xFF.
- R2: A store into the window (WIN_BASE up to WIN_BASE + PAGE_BYTES*NUM_PAGES - 1) changes no byte read back from the window. It loads the buffer byte at the address modulo PAGE_BYTES and marks that byte as written.
- R3: After a store into the window, the address register (low byte at REG_BASE+4, high byte at REG_BASE+5) reads back the address of that store.
- R4: While `unlock` is high, writing 0x03 to the command register (REG_BASE+0) starts an erase/write. Status bit 0 (REG_BASE+1) and `busy` stay high for exactly PROG_CYCLES cycles, and the command register reads 0x03 during that time. When the write ends, flag bit 0 (REG_BASE+2) and `done_irq` set. Writing a byte with bit 0 = 1 to REG_BASE+2 clears the flag, and writing bit 0 = 0 leaves it set.
- R5: A command write while `unlock` is low is ignored: the controller does not go busy and the array is unchanged.
- R6: An erase/write changes only the page that holds the address register. In that page, each byte marked as written takes its buffered value and each unmarked byte becomes 0xFF.
- R7: While the controller is busy, window stores and command writes are ignored. They change neither the buffer, nor the address register, nor the page that is written.
- R8: While `unlock` is high, writing 0x04 to the command register clears every written mark and sets every buffer byte to 0xFF, so a later erase/write fills the page with 0xFF except for bytes stored after the clear.
- R9: Reads of the window return the array contents, never the buffer, and the pages not addressed by an erase/write keep their contents.
- R10: A command code other than 0x03 or 0x04 is ignored, and the command register reads 0 whenever no erase/write is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access valid |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| unlock | input | 1 | Command unlock window open |
| busy | output | 1 | Erase/write in progress |
| done_irq | output | 1 | Completion flag |

## Verification
The bench uses 8-byte pages, 4 pages and a 12-cycle programming time. With these values, random stores often hit the same buffer offset and the same page more than once, and every page is committed many times within a short run. The short busy window allows exact cycle counts on every commit. It also makes room for attempts to store and to issue commands while a write is still running. A bench-side model of the array, the buffer and the written marks predicts every byte after each commit.

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 8,
  parameter int PROG_CYCLES = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1400,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              unlock,
  output logic              busy,
  output logic              done_irq
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PG_W     = $clog2(NUM_PAGES);
  localparam int EA_W     = OFF_W + PG_W;
  localparam int EE_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int CNT_W    = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W:0] EE_SZ = (ADDR_W+1)'(EE_BYTES);
  localparam logic [2:0] SEL_CMD = 3'd0, SEL_STAT = 3'd1, SEL_FLAG = 3'd2,
                         SEL_ALO = 3'd4, SEL_AHI = 3'd5;
  localparam logic [7:0] OP_WRITE = 8'h03, OP_CLEAR = 8'h04;

  logic [7:0]            mem  [EE_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmark;
  logic [ADDR_W-1:0]     addr_q;
  logic [PG_W-1:0]       pg_q;
  logic                  busy_q, done_q;
  logic [CNT_W-1:0]      cnt;

  logic [ADDR_W-1:0] win_off;
  logic in_win, reg_hit, wr, st_win, cmd_wr, do_clr, do_prog, finish, flag_clr;
  logic [2:0] reg_sel;

  assign win_off  = bus_addr - WIN_BASE;
  assign in_win   = {1'b0, win_off} < EE_SZ;
  assign reg_hit  = bus_addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3];
  assign reg_sel  = bus_addr[2:0];
  assign wr       = bus_req & bus_we;
  assign st_win   = wr & in_win & ~busy_q;
  assign cmd_wr   = wr & reg_hit & (reg_sel == SEL_CMD) & unlock & ~busy_q;
  assign do_clr   = cmd_wr & (bus_wdata == OP_CLEAR);
  assign do_prog  = cmd_wr & (bus_wdata == OP_WRITE);
  assign finish   = busy_q & (cnt == '0);
  assign flag_clr = wr & reg_hit & (reg_sel == SEL_FLAG) & bus_wdata[0];

  assign busy     = busy_q;
  assign done_irq = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      pmark  <= '0;
      addr_q <= '0;
      pg_q   <= '0;
    end else if (do_clr) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      pmark <= '0;
    end else if (st_win) begin
      pbuf[win_off[OFF_W-1:0]]  <= bus_wdata;
      pmark[win_off[OFF_W-1:0]] <= 1'b1;
      addr_q <= bus_addr;
      pg_q   <= win_off[EA_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      if (do_prog) begin
        busy_q <= 1'b1;
        cnt    <= CNT_W'(PROG_CYCLES - 1);
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt <= cnt - 1'b1;
      end
      if (finish)        done_q <= 1'b1;
      else if (flag_clr) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EE_BYTES; i++) mem[i] <= 8'hFF;
    end else if (finish) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem[{pg_q, OFF_W'(i)}] <= pmark[i] ? pbuf[i] : 8'hFF;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (in_win) bus_rdata = mem[win_off[EA_W-1:0]];
    else if (reg_hit) begin
      case (reg_sel)
        SEL_CMD:  bus_rdata = busy_q ? OP_WRITE : 8'h00;
        SEL_STAT: bus_rdata = {7'b0, busy_q};
        SEL_FLAG: bus_rdata = {7'b0, done_q};
        SEL_ALO:  bus_rdata = addr_q[7:0];
        SEL_AHI:  bus_rdata = 8'(addr_q >> 8);
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nvm_page_ctrl_chk.sv
module nvm_page_ctrl_chk #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 8,
  parameter int PROG_CYCLES = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1400,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              unlock,
  input logic              busy,
  input logic              done_irq,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(PAGE_BYTES * NUM_PAGES);

  logic w_cmd, w_flag, w_win;
  int   bc;

  assign w_cmd  = bus_req && bus_we && bus_addr == REG_BASE;
  assign w_flag = bus_req && bus_we && bus_addr == REG_BASE + ADDR_W'(2);
  assign w_win  = bus_req && bus_we && bus_addr >= WIN_BASE && bus_addr < WIN_END;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bc <= 0;
    else if (busy) bc <= bc + 1;
    else           bc <= 0;

  AST_LOCKED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd && !unlock && !busy) |=> !busy); // R5
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd && unlock && !busy && bus_wdata != 8'h03) |=> !busy); // R10
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq); // R4
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(busy)); // R4
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (w_flag && bus_wdata[0] && !busy) |=> !done_irq); // R4
  AST_PROG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bc == PROG_CYCLES); // R4
  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (w_win && !busy) |=> addr_q == $past(bus_addr)); // R3
  AST_BUSY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_win && busy) |=> $stable(addr_q)); // R7
endmodule

bind nvm_page_ctrl nvm_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
  .PROG_CYCLES(PROG_CYCLES), .WIN_BASE(WIN_BASE), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlock(unlock),
  .busy(busy_q), .done_irq(done_q), .addr_q(addr_q)
);

// File: tb/sim_nvm_page_ctrl.sv
module sim_nvm_page_ctrl;
  localparam int PB = 8, NP = 4, PC = 12, EB = PB * NP;
  localparam logic [15:0] WB = 16'h1400, RB = 16'h1000;

  logic clk = 0, rst_n = 0, bus_req = 0, bus_we = 0, unlock = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic busy, done_irq;

  nvm_page_ctrl #(.ADDR_W(16), .PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_CYCLES(PC),
                  .WIN_BASE(WB), .REG_BASE(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlock(unlock), .busy(busy),
    .done_irq(done_irq));

  always #4 clk = ~clk;

  int checks = 0, errs = 0;
  bit finished = 0;
  logic [7:0]  mm [EB];
  logic [7:0]  mb [PB];
  logic        mk [PB];
  logic [15:0] maddr;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic m_store(input logic [15:0] a, input logic [7:0] d);
    mb[(a - WB) % PB] = d; mk[(a - WB) % PB] = 1; maddr = a;
  endtask

  task automatic m_clear();
    for (int i = 0; i < PB; i++) begin mb[i] = 8'hFF; mk[i] = 0; end
  endtask

  task automatic m_commit();
    int pg;
    pg = (maddr - WB) / PB;
    for (int i = 0; i < PB; i++) mm[pg*PB + i] = mk[i] ? mb[i] : 8'hFF;
  endtask

  task automatic check_array(input string req);
    logic [7:0] d;
    for (int i = 0; i < EB; i++) begin
      rd(WB + 16'(i), d);
      chk(req, d, mm[i]);
    end
  endtask

  task automatic wait_prog(output int n);
    logic [7:0] s;
    n = 0;
    rd(RB + 1, s);
    while (s[0] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(RB + 1, s);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R4 watchdog got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < EB; i++) mm[i] = 8'hFF;
    m_clear(); maddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(RB, d);     chk("R1 cmd", d, 0);
    rd(RB + 1, d); chk("R1 status", d, 0);
    rd(RB + 2, d); chk("R1 flag", d, 0);
    rd(RB + 4, d); chk("R1 addr lo", d, 0);
    rd(RB + 5, d); chk("R1 addr hi", d, 0);
    check_array("R1 array");

    // R2/R3 store lands in buffer only
    wr(WB + 3, 8'h5A); m_store(WB + 3, 8'h5A);
    rd(WB + 3, d); chk("R2 window unchanged", d, 8'hFF);
    rd(RB + 4, d); chk("R3 addr lo", d, 8'h03);
    rd(RB + 5, d); chk("R3 addr hi", d, 8'h14);

    // R5 locked command
    unlock = 0;
    wr(RB, 8'h03);
    rd(RB + 1, d); chk("R5 locked not busy", d, 0);
    check_array("R5 array unchanged");

    // R10 unknown code
    unlock = 1;
    wr(RB, 8'h07);
    rd(RB + 1, d); chk("R10 bad code not busy", d, 0);
    rd(RB, d);     chk("R10 cmd idle reads 0", d, 0);

    // R4 erase/write timing, flag
    wr(RB, 8'h03);
    rd(RB, d); chk("R4 cmd reads 03 while busy", d, 8'h03);
    chk("R4 busy pin", busy, 1);
    wait_prog(n); chk("R4 busy cycles", n, PC);
    m_commit();
    rd(RB + 2, d); chk("R4 flag set", d, 1);
    chk("R4 done_irq", done_irq, 1);
    rd(RB, d); chk("R10 cmd 0 after write", d, 0);
    check_array("R6 page0 merge");
    wr(RB + 2, 8'h00);
    rd(RB + 2, d); chk("R4 flag kept on 0 write", d, 1);
    wr(RB + 2, 8'h01);
    rd(RB + 2, d); chk("R4 flag cleared", d, 0);

    // R7 activity during busy is ignored
    wr(WB + 18, 8'h77); m_store(WB + 18, 8'h77);
    wr(RB, 8'h03);
    wr(WB + 5, 8'h22);
    wr(RB, 8'h04);
    wr(RB, 8'h03);
    wait_prog(n);
    m_commit();
    rd(RB + 4, d); chk("R7 addr kept", d, 8'h12);
    check_array("R7 page2 unaffected by busy traffic");
    wr(RB + 2, 8'h01);

    // R8 clear then store
    wr(RB, 8'h04); m_clear();
    rd(RB + 1, d); chk("R8 clear not busy", d, 0);
    wr(WB + 25, 8'h3C); m_store(WB + 25, 8'h3C);
    wr(RB, 8'h03);
    wait_prog(n); chk("R4 busy cycles after clear", n, PC);
    m_commit();
    check_array("R8 page3 after clear");
    wr(RB + 2, 8'h01);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int k;
      if ($urandom_range(1) == 1) begin wr(RB, 8'h04); m_clear(); end
      k = $urandom_range(10, 1);
      for (int j = 0; j < k; j++) begin
        logic [15:0] a;
        logic [7:0] v;
        a = WB + 16'($urandom_range(EB - 1));
        v = 8'($urandom);
        wr(a, v); m_store(a, v);
        rd(a, d); chk("R9 read returns array", d, mm[a - WB]);
      end
      rd(RB + 4, d); chk("R3 addr random", d, maddr[7:0]);
      if ($urandom_range(2) == 0) begin
        unlock = 0;
        wr(RB, 8'h03);
        rd(RB + 1, d); chk("R5 random locked", d, 0);
        unlock = 1;
      end
      wr(RB, 8'h03);
      wait_prog(n); chk("R4 random busy cycles", n, PC);
      m_commit();
      check_array("R6 R9 random commit");
      rd(RB + 2, d); chk("R4 random flag", d, 1);
      wr(RB + 2, 8'h01);
      rd(RB + 2, d); chk("R4 random flag clear", d, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule